// File: doc/BRIEF.md
# Extended Port Control Window with Test FIFO

This block is the secondary register window of a parallel port that supports the extended transfer modes. A host reaches it over a byte-wide bus with a 3-bit offset, one access per cycle. Three offsets carry state. The first is a shared data slot at offset 0. The second is a free configuration byte at offset 1. The third is the extended control register (ECR) at offset 2. The ECR's top field selects the port's operating mode, and its two low bits report the fill level of a small byte FIFO.

The FIFO can be reached only while the mode field is set to FIFO test. In that mode a write to offset 0 pushes a byte and a read from offset 0 pops one. In the other modes offset 0 is an ordinary storage byte, except in configuration mode, where it reads back a fixed capability byte. Any ECR write that changes the mode field empties the FIFO, so software can always return it to a known state. Read data is combinational from the current state while `rdEn` is high. A pop takes effect at the clock edge that ends the read.

Top module: `ecpWindow`

## Requirements
- R1: After reset the ECR reads 0x01 (mode 0, bits 4:2 zero, fill code empty), and offset 1 and the offset-0 storage byte read 0x00.
- R2: An ECR write at offset 2 stores bits 7:2 exactly as written, replacing the previous mode outright. Bits 1:0 of the written value are discarded, and on read they always show the fill code.
- R3: In FIFO-test mode (mode 6), writes at offset 0 push bytes and reads pop them in first-in first-out order. The fill code is 01 when empty, 10 when all DEPTH entries (default 2) are held, and 00 otherwise.
- R4: A push while the FIFO is full is ignored: the stored bytes and the fill code stay unchanged.
- R5: A pop while the FIFO is empty returns the byte most recently popped (0x00 if none since reset), and the fill code stays 01.
- R6: An ECR write whose bits 7:5 differ from the current mode empties the FIFO and sets the fill code to 01. An ECR write that keeps the same mode leaves the FIFO contents intact.
- R7: In modes 0 to 5, offset 0 is a plain read/write byte, and accesses to it never touch the FIFO.
- R8: Offset 1 is a read/write byte register in every mode.
- R9: Offsets 3 to 7 read as 0xFF, and writes to them change no state.
- R10: In configuration mode (mode 7), a read at offset 0 returns 0x10, the capability byte whose bits 6:4 hold width code 1 (8-bit). Writes at offset 0 in that mode are ignored.
- R11: The FIFO pointers wrap at DEPTH, so repeated fill and drain cycles keep the byte order correct.
- R12: When `wrEn` and `rdEn` are both high, the write is performed and the read has no side effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| regSel | input | 3 | Register offset within the window |
| wrEn | input | 1 | Write strobe for one cycle |
| rdEn | input | 1 | Read strobe for one cycle; a FIFO pop happens at the closing edge |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for the selected offset, valid while rdEn is high |

## Verification
The hardest state to reach is a mode-change flush while the FIFO is partly or fully occupied, followed by a pop on the now empty FIFO, which must return the byte popped before the flush. A random walk rarely lines these up. Directed sequences therefore fill the FIFO, pop some entries, rewrite the ECR with the same mode and then with a different one, and pop again. The random phase biases ECR writes toward test mode, so that overflow, underflow and pointer wrap recur many times against the bench's queue model.

// File: rtl/ecpWindow_pkg.sv
package ecpWindow_pkg;

  typedef enum logic [2:0] {
    MODE_COMPAT  = 3'd0,
    MODE_BYTE    = 3'd1,
    MODE_PPFIFO  = 3'd2,
    MODE_ECPFIFO = 3'd3,
    MODE_EPP     = 3'd4,
    MODE_RSVD    = 3'd5,
    MODE_TEST    = 3'd6,
    MODE_CONFIG  = 3'd7
  } chipMode_e;

  typedef enum logic [2:0] {
    SRC_PLAIN = 3'd0,
    SRC_FIFO  = 3'd1,
    SRC_CFGA  = 3'd2,
    SRC_CFGB  = 3'd3,
    SRC_ECR   = 3'd4,
    SRC_NONE  = 3'd5
  } readSrc_e;

  localparam logic [1:0] FILL_PART  = 2'b00;
  localparam logic [1:0] FILL_EMPTY = 2'b01;
  localparam logic [1:0] FILL_FULL  = 2'b10;

  localparam logic [2:0] OFS_DATA = 3'd0;
  localparam logic [2:0] OFS_CFGB = 3'd1;
  localparam logic [2:0] OFS_ECR  = 3'd2;

  localparam logic [7:0] CFGA_VALUE = 8'h10;
  localparam logic [7:0] IDLE_READ  = 8'hFF;

  typedef struct packed {
    logic     push;
    logic     pop;
    logic     plainWr;
    logic     cfgBWr;
    readSrc_e readSrc;
  } strobe_t;

endpackage

// File: rtl/ecpCtrl.sv
module ecpCtrl
  import ecpWindow_pkg::*;
#(
  parameter int DEPTH = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [2:0]           regSel,
  input  logic                 wrEn,
  input  logic                 rdEn,
  input  logic [7:0]           wrData,
  output strobe_t              strobe,
  output logic [PTR_W-1:0]     wrIdx,
  output logic [PTR_W-1:0]     rdIdx,
  output logic                 fifoEmpty,
  output logic [7:0]           ecrValue
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);

  chipMode_e        mode;
  logic [2:0]       ecrMid;
  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] rdPtr;
  logic [CNT_W-1:0] fillCnt;

  logic wrAct, rdAct, isTest, isConfig, ecrWr, modeChange, fifoFull;
  logic [1:0] fillCode;

  function automatic logic [PTR_W-1:0] bumpPtr(input logic [PTR_W-1:0] p);
    return (p == LAST_IDX) ? '0 : p + PTR_W'(1);
  endfunction

  always_comb begin
    wrAct      = wrEn;
    rdAct      = rdEn && !wrEn;
    isTest     = (mode == MODE_TEST);
    isConfig   = (mode == MODE_CONFIG);
    ecrWr      = wrAct && (regSel == OFS_ECR);
    modeChange = ecrWr && (wrData[7:5] != mode);
    fifoFull   = (fillCnt == FULL_CNT);
    fifoEmpty  = (fillCnt == '0);
  end

  always_comb begin
    if (fifoEmpty)     fillCode = FILL_EMPTY;
    else if (fifoFull) fillCode = FILL_FULL;
    else               fillCode = FILL_PART;
  end

  assign ecrValue = {mode, ecrMid, fillCode};
  assign wrIdx    = wrPtr;
  assign rdIdx    = rdPtr;

  always_comb begin
    strobe.push    = wrAct && (regSel == OFS_DATA) && isTest && !fifoFull;
    strobe.pop     = rdAct && (regSel == OFS_DATA) && isTest && !fifoEmpty;
    strobe.plainWr = wrAct && (regSel == OFS_DATA) && !isTest && !isConfig;
    strobe.cfgBWr  = wrAct && (regSel == OFS_CFGB);
    case (regSel)
      OFS_DATA: begin
        if (isTest)        strobe.readSrc = SRC_FIFO;
        else if (isConfig) strobe.readSrc = SRC_CFGA;
        else               strobe.readSrc = SRC_PLAIN;
      end
      OFS_CFGB: strobe.readSrc = SRC_CFGB;
      OFS_ECR:  strobe.readSrc = SRC_ECR;
      default:  strobe.readSrc = SRC_NONE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mode    <= MODE_COMPAT;
      ecrMid  <= '0;
      wrPtr   <= '0;
      rdPtr   <= '0;
      fillCnt <= '0;
    end else if (ecrWr) begin
      mode   <= chipMode_e'(wrData[7:5]);
      ecrMid <= wrData[4:2];
      if (modeChange) begin
        wrPtr   <= '0;
        rdPtr   <= '0;
        fillCnt <= '0;
      end
    end else if (strobe.push) begin
      wrPtr   <= bumpPtr(wrPtr);
      fillCnt <= fillCnt + CNT_W'(1);
    end else if (strobe.pop) begin
      rdPtr   <= bumpPtr(rdPtr);
      fillCnt <= fillCnt - CNT_W'(1);
    end
  end

  assert_fill_bound_R3: assert property (@(posedge clk) disable iff (!rstN)
    fillCnt <= FULL_CNT);

  assert_full_push_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && regSel == OFS_DATA && mode == MODE_TEST && fillCnt == FULL_CNT)
    |=> (fillCnt == FULL_CNT) && $stable(wrPtr));

  assert_empty_pop_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !wrEn && regSel == OFS_DATA && mode == MODE_TEST && fillCnt == '0)
    |=> $stable(rdPtr) && (ecrValue[1:0] == FILL_EMPTY));

  assert_mode_flush_R6: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && regSel == OFS_ECR && wrData[7:5] != mode)
    |=> (ecrValue[1:0] == FILL_EMPTY));

  assert_high_window_ignore_R9: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && regSel > OFS_ECR) |=> $stable(ecrValue));

endmodule

// File: rtl/ecpData.sv
module ecpData
  import ecpWindow_pkg::*;
#(
  parameter int DEPTH = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strobe,
  input  logic [PTR_W-1:0] wrIdx,
  input  logic [PTR_W-1:0] rdIdx,
  input  logic             fifoEmpty,
  input  logic [7:0]       ecrValue,
  input  logic [7:0]       wrData,
  output logic [7:0]       rdData
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [7:0] fifoMem [DEPTH];
  logic [7:0] lastRead;
  logic [7:0] plainReg;
  logic [7:0] cfgBReg;
  logic [7:0] headByte;

  assign headByte = fifoMem[rdIdx];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) fifoMem[i] <= '0;
    end else if (strobe.push) begin
      fifoMem[wrIdx] <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastRead <= '0;
      plainReg <= '0;
      cfgBReg  <= '0;
    end else begin
      if (strobe.pop)     lastRead <= headByte;
      if (strobe.plainWr) plainReg <= wrData;
      if (strobe.cfgBWr)  cfgBReg  <= wrData;
    end
  end

  always_comb begin
    case (strobe.readSrc)
      SRC_PLAIN: rdData = plainReg;
      SRC_FIFO:  rdData = fifoEmpty ? lastRead : headByte;
      SRC_CFGA:  rdData = CFGA_VALUE;
      SRC_CFGB:  rdData = cfgBReg;
      SRC_ECR:   rdData = ecrValue;
      default:   rdData = IDLE_READ;
    endcase
  end

  assert_push_spares_plain_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.push |=> $stable(plainReg));

  assert_plain_spares_fifo_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.plainWr |=> $stable(lastRead));

endmodule

// File: rtl/ecpWindow.sv
module ecpWindow
  import ecpWindow_pkg::*;
#(
  parameter int DEPTH = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] regSel,
  input  logic       wrEn,
  input  logic       rdEn,
  input  logic [7:0] wrData,
  output logic [7:0] rdData
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  strobe_t          strobe;
  logic [PTR_W-1:0] wrIdx;
  logic [PTR_W-1:0] rdIdx;
  logic             fifoEmpty;
  logic [7:0]       ecrValue;

  ecpCtrl #(.DEPTH(DEPTH)) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .regSel    (regSel),
    .wrEn      (wrEn),
    .rdEn      (rdEn),
    .wrData    (wrData),
    .strobe    (strobe),
    .wrIdx     (wrIdx),
    .rdIdx     (rdIdx),
    .fifoEmpty (fifoEmpty),
    .ecrValue  (ecrValue)
  );

  ecpData #(.DEPTH(DEPTH)) data_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .wrIdx     (wrIdx),
    .rdIdx     (rdIdx),
    .fifoEmpty (fifoEmpty),
    .ecrValue  (ecrValue),
    .wrData    (wrData),
    .rdData    (rdData)
  );

endmodule

// File: tb/ecpWindow_tb_top.sv
module ecpWindow_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int FIFO_DEPTH = 2;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] regSel = '0;
  logic       wrEn = 1'b0;
  logic       rdEn = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;

  int testCnt = 0;
  int failCnt = 0;
  bit finished = 1'b0;

  // reference model state
  logic [5:0] mHi = 6'd0;
  logic [7:0] mQ[$];
  logic [7:0] mLast = 8'h00;
  logic [7:0] mPlain = 8'h00;
  logic [7:0] mCfgB = 8'h00;

  always #(CLK_PERIOD/2) clk = ~clk;

  ecpWindow #(.DEPTH(FIFO_DEPTH)) dut_i (
    .clk(clk), .rstN(rstN), .regSel(regSel), .wrEn(wrEn),
    .rdEn(rdEn), .wrData(wrData), .rdData(rdData)
  );

  function automatic logic [1:0] expFill();
    if (mQ.size() == 0) return 2'b01;
    if (mQ.size() == FIFO_DEPTH) return 2'b10;
    return 2'b00;
  endfunction

  function automatic string tagFor(input logic [2:0] s);
    if (s == 3'd0) begin
      if (mHi[5:3] == 3'd6) return "R3";
      if (mHi[5:3] == 3'd7) return "R10";
      return "R7";
    end
    if (s == 3'd1) return "R8";
    if (s == 3'd2) return "R2";
    return "R9";
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    testCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic [2:0] s, input logic [7:0] d);
    @(negedge clk);
    regSel = s; wrData = d; wrEn = 1'b1; rdEn = 1'b0;
    @(posedge clk);
    #1 wrEn = 1'b0;
    case (s)
      3'd0: begin
        if (mHi[5:3] == 3'd6) begin
          if (mQ.size() < FIFO_DEPTH) mQ.push_back(d);
        end else if (mHi[5:3] != 3'd7) begin
          mPlain = d;
        end
      end
      3'd1: mCfgB = d;
      3'd2: begin
        if (d[7:5] != mHi[5:3]) mQ.delete();
        mHi = d[7:2];
      end
      default: ;
    endcase
  endtask

  task automatic rdReg(input logic [2:0] s, input string req);
    logic [7:0] exp;
    @(negedge clk);
    regSel = s; rdEn = 1'b1; wrEn = 1'b0;
    case (s)
      3'd0: begin
        if (mHi[5:3] == 3'd6) begin
          if (mQ.size() > 0) begin
            exp = mQ.pop_front();
            mLast = exp;
          end else begin
            exp = mLast;
          end
        end else if (mHi[5:3] == 3'd7) exp = 8'h10;
        else exp = mPlain;
      end
      3'd1: exp = mCfgB;
      3'd2: exp = {mHi, expFill()};
      default: exp = 8'hFF;
    endcase
    #1 check(req, rdData, exp);
    @(posedge clk);
    #1 rdEn = 1'b0;
  endtask

  // both strobes high: write wins, read has no side effect
  task automatic wrRdBoth(input logic [2:0] s, input logic [7:0] d);
    @(negedge clk);
    regSel = s; wrData = d; wrEn = 1'b1; rdEn = 1'b1;
    @(posedge clk);
    #1 begin wrEn = 1'b0; rdEn = 1'b0; end
    if (s == 3'd0 && mHi[5:3] == 3'd6 && mQ.size() < FIFO_DEPTH) mQ.push_back(d);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failCnt++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1 reset state
    rdReg(3'd2, "R1");
    rdReg(3'd1, "R1");
    rdReg(3'd0, "R1");

    // R2 ECR store, low bits ignored
    wrReg(3'd2, 8'hDF);
    rdReg(3'd2, "R2");
    wrReg(3'd2, 8'hC2);
    rdReg(3'd2, "R2");

    // R3 order and fill codes
    wrReg(3'd0, 8'hA1);
    rdReg(3'd2, "R3");
    wrReg(3'd0, 8'hB2);
    rdReg(3'd2, "R3");
    rdReg(3'd0, "R3");
    rdReg(3'd0, "R3");
    rdReg(3'd2, "R3");

    // R4 overflow ignored
    wrReg(3'd0, 8'hC3);
    wrReg(3'd0, 8'hD4);
    wrReg(3'd0, 8'hE5);
    rdReg(3'd2, "R4");
    rdReg(3'd0, "R4");
    rdReg(3'd0, "R4");

    // R5 underflow returns last popped
    rdReg(3'd0, "R5");
    rdReg(3'd2, "R5");

    // R11 wrap over several fill/drain rounds
    for (int k = 0; k < 3; k++) begin
      wrReg(3'd0, 8'(8'h30 + k));
      wrReg(3'd0, 8'(8'h40 + k));
      rdReg(3'd0, "R11");
      wrReg(3'd0, 8'(8'h50 + k));
      rdReg(3'd0, "R11");
      rdReg(3'd0, "R11");
    end

    // R6 same-mode write keeps, mode change flushes
    wrReg(3'd0, 8'h66);
    wrReg(3'd2, 8'hC4);
    rdReg(3'd2, "R6");
    wrReg(3'd2, 8'h00);
    wrReg(3'd2, 8'hC0);
    rdReg(3'd2, "R6");
    rdReg(3'd0, "R6");

    // R7 plain byte in other modes, FIFO untouched
    wrReg(3'd2, 8'h20);
    wrReg(3'd0, 8'h5A);
    rdReg(3'd0, "R7");
    wrReg(3'd2, 8'hC0);
    rdReg(3'd2, "R7");

    // R10 configuration mode
    wrReg(3'd2, 8'hE0);
    rdReg(3'd0, "R10");
    wrReg(3'd0, 8'h77);
    wrReg(3'd2, 8'h40);
    rdReg(3'd0, "R10");

    // R8 configuration byte
    wrReg(3'd1, 8'h3C);
    rdReg(3'd1, "R8");

    // R9 upper offsets
    for (int s = 3; s < 8; s++) begin
      wrReg(3'(s), 8'h00);
      rdReg(3'(s), "R9");
    end
    rdReg(3'd2, "R9");
    rdReg(3'd1, "R9");
    rdReg(3'd0, "R9");

    // R12 simultaneous write and read
    wrReg(3'd2, 8'hC0);
    wrRdBoth(3'd0, 8'h91);
    wrRdBoth(3'd0, 8'h92);
    rdReg(3'd2, "R12");
    rdReg(3'd0, "R12");
    rdReg(3'd0, "R12");

    // random phase
    for (int n = 0; n < 4000; n++) begin
      int r;
      logic [2:0] s;
      logic [7:0] d;
      r = int'($urandom % 16);
      d = 8'($urandom);
      if (r < 2) begin
        case ($urandom % 6)
          0, 1, 2: d[7:5] = 3'd6;
          3: d[7:5] = 3'd0;
          4: d[7:5] = 3'd7;
          default: d[7:5] = 3'd2;
        endcase
        wrReg(3'd2, d);
      end else begin
        s = (r < 11) ? 3'd0 : 3'($urandom % 8);
        if ($urandom % 2 == 0) wrReg(s, d);
        else rdReg(s, tagFor(s));
      end
    end

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

endmodule